// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an EDO DRAM's contents alive and brings the part up after reset. Once reset is released it holds the memory's strobes idle for a power-up pause. It then runs a fixed number of initialization refresh cycles and raises `init_done` so the access controller may start normal traffic. Until that point it keeps ownership of the strobe pins.

After initialization an interval timer adds one refresh to a backlog every `REFI_CYCLES` clocks. The default is 1560 clocks at 100 MHz, which spreads 2048 refreshes evenly over 32 ms. While the backlog is non-zero the block asserts `ref_req`. The access controller answers with a one-clock `ref_gnt` when the pins are free.

The block then takes the pins (`pin_own`) and runs every pending refresh back to back. It gives the pins back when the backlog is empty. Each refresh is a CAS-before-RAS cycle with write-enable held high, so the memory's internal row counter chooses the row and test mode is never entered. The backlog saturates at `MAX_PENDING`, so a long stall in granting does not lose the refreshes it has counted.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset `ras_n`, `cas_n` and `we_n` are 1, `init_done` and `ref_req` are 0, and `pin_own` is 1.
- R2: After reset is released, no strobe goes low during the pause. The first `cas_n` fall happens exactly `PAUSE_CYCLES + T_RP` clocks after release, because the pause is followed by one precharge phase.
- R3: Every cycle is CAS-before-RAS: `cas_n` is low for at least `T_CSR` clocks while `ras_n` is still high before `ras_n` falls. `cas_n` stays low for the whole time `ras_n` is low.
- R4: `we_n` is 1 at every `ras_n` fall, so test mode is never entered.
- R5: `ras_n` stays low for exactly `T_RAS` clocks per cycle. Before each fall, `ras_n` is high for at least `T_RP` clocks, including between back-to-back cycles.
- R6: Exactly `INIT_CYCLES` refresh cycles run before `init_done` rises. After that, `init_done` stays at 1 until reset.
- R7: While `init_done` is 0, `pin_own` is 1, `ref_req` is 0, and `ref_gnt` has no effect on the initialization sequence.
- R8: `ref_req` rises exactly `REFI_CYCLES` clocks after `init_done` rises. It then stays high until a grant is taken.
- R9: A grant sets `pin_own` to 1 from the next clock. Every pending refresh then runs back to back, after which `pin_own` and `ref_req` return to 0.
- R10: The backlog saturates at `MAX_PENDING`. Ticks that arrive while it is full are dropped, so a later grant runs exactly `MAX_PENDING` cycles.
- R11: A `ref_gnt` pulse while `ref_req` is 0 starts no cycle: `pin_own` stays 0 and both strobes stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | One-clock grant from the access controller |
| ref_req | output | 1 | Refresh backlog is non-zero and pins are wanted |
| init_done | output | 1 | Power-up pause and initialization burst complete |
| pin_own | output | 1 | Block drives the strobe pins; controller must mux them through |
| ras_n | output | 1 | Row strobe to the DRAM (active low) |
| cas_n | output | 1 | Column strobe to the DRAM (active low) |
| we_n | output | 1 | Write enable to the DRAM (active low, held high) |

## Verification
The assertions assume that `ref_gnt` is a single-clock pulse from a controller that has already released the pins. They also assume that the timing parameters are at least one clock each. The stimulus therefore drives the grant as a one-clock pulse taken at a falling clock edge. It uses small but legal parameter values.

The one exception is during the pause and the initialization burst, where the grant is held high on purpose to show that it is ignored there. Grants are placed so that a burst always completes well before the next interval tick. This keeps the expected number of back-to-back cycles exact.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [1:0] {
        ST_PAUSE,
        ST_INIT,
        ST_IDLE,
        ST_BURST
    } sched_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PRE,
        PH_CSET,
        PH_RLOW
    } cbr_phase_e;

endpackage

// File: rtl/dref_interval_timer.sv
module dref_interval_timer #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_reg_t;

    tmr_reg_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        tick = en && (r_q.cnt == CW'(PERIOD - 1));
        if (!en)       r_d.cnt = '0;
        else if (tick) r_d.cnt = '0;
        else           r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/dref_backlog.sv
module dref_backlog #(
    parameter int MAX_PENDING = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nonzero,
    output logic more_than_one
);
    localparam int BW = $clog2(MAX_PENDING + 1);

    typedef struct packed {
        logic [BW-1:0] count;
    } blg_reg_t;

    blg_reg_t r_d, r_q;
    logic     inc_eff;

    always_comb begin
        r_d     = r_q;
        inc_eff = inc && (r_q.count != BW'(MAX_PENDING));
        case ({inc_eff, dec})
            2'b10:   r_d.count = r_q.count + 1'b1;
            2'b01:   r_d.count = r_q.count - 1'b1;
            default: r_d.count = r_q.count;
        endcase
        nonzero       = (r_q.count != '0);
        more_than_one = (r_q.count > BW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/dref_cbr_seq.sv
module dref_cbr_seq
    import dref_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_CSR = 1,
    parameter int T_RAS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ras_n,
    output logic cas_n,
    output logic done
);
    localparam int TMAX_A = (T_RP > T_CSR) ? T_RP : T_CSR;
    localparam int TMAX   = (TMAX_A > T_RAS) ? TMAX_A : T_RAS;
    localparam int CW     = $clog2(TMAX + 1);

    typedef struct packed {
        cbr_phase_e    phase;
        logic [CW-1:0] cnt;
        logic          ras_n;
        logic          cas_n;
    } seq_reg_t;

    seq_reg_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = (s_q.phase == PH_RLOW) && (s_q.cnt == '0);
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_PRE;
                    s_d.cnt   = CW'(T_RP - 1);
                end
            end
            PH_PRE: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_CSET;
                    s_d.cnt   = CW'(T_CSR - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_CSET: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_RLOW;
                    s_d.cnt   = CW'(T_RAS - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: begin
                if (s_q.cnt == '0) begin
                    if (start) begin
                        s_d.phase = PH_PRE;
                        s_d.cnt   = CW'(T_RP - 1);
                    end else begin
                        s_d.phase = PH_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        endcase
        s_d.ras_n = (s_d.phase != PH_RLOW);
        s_d.cas_n = !((s_d.phase == PH_CSET) || (s_d.phase == PH_RLOW));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.ras_n <= 1'b1;
            s_q.cas_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ras_n = s_q.ras_n;
    assign cas_n = s_q.cas_n;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dref_pkg::*;
#(
    parameter int REFI_CYCLES  = 1560,
    parameter int PAUSE_CYCLES = 20000,
    parameter int INIT_CYCLES  = 8,
    parameter int MAX_PENDING  = 8,
    parameter int T_RP         = 3,
    parameter int T_CSR        = 1,
    parameter int T_RAS        = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic init_done,
    output logic pin_own,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    localparam int PW = $clog2(PAUSE_CYCLES + 1);
    localparam int IW = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        sched_state_e  state;
        logic [PW-1:0] pcnt;
        logic [IW-1:0] left;
        logic          init_done;
    } top_reg_t;

    top_reg_t t_d, t_q;
    logic     seq_start, seq_done, tick, pend_dec, pend_nz, pend_multi;

    dref_interval_timer #(.PERIOD(REFI_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (t_q.init_done),
        .tick  (tick)
    );

    dref_backlog #(.MAX_PENDING(MAX_PENDING)) u_backlog (
        .clk           (clk),
        .rst_n         (rst_n),
        .inc           (tick),
        .dec           (pend_dec),
        .nonzero       (pend_nz),
        .more_than_one (pend_multi)
    );

    dref_cbr_seq #(.T_RP(T_RP), .T_CSR(T_CSR), .T_RAS(T_RAS)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (seq_start),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .done  (seq_done)
    );

    always_comb begin
        t_d       = t_q;
        seq_start = 1'b0;
        pend_dec  = 1'b0;
        case (t_q.state)
            ST_PAUSE: begin
                if (t_q.pcnt == PW'(PAUSE_CYCLES - 1)) begin
                    t_d.state = ST_INIT;
                    t_d.left  = IW'(INIT_CYCLES);
                    seq_start = 1'b1;
                end else begin
                    t_d.pcnt = t_q.pcnt + 1'b1;
                end
            end
            ST_INIT: begin
                if (seq_done) begin
                    if (t_q.left == IW'(1)) begin
                        t_d.state     = ST_IDLE;
                        t_d.init_done = 1'b1;
                    end else begin
                        t_d.left  = t_q.left - 1'b1;
                        seq_start = 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                if (pend_nz && ref_gnt) begin
                    t_d.state = ST_BURST;
                    seq_start = 1'b1;
                end
            end
            default: begin
                if (seq_done) begin
                    pend_dec = 1'b1;
                    if (pend_multi) seq_start = 1'b1;
                    else            t_d.state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.state     <= ST_PAUSE;
            t_q.pcnt      <= '0;
            t_q.left      <= '0;
            t_q.init_done <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign ref_req   = (t_q.state == ST_IDLE) && pend_nz;
    assign pin_own   = (t_q.state != ST_IDLE);
    assign init_done = t_q.init_done;
    assign we_n      = 1'b1;
endmodule

// File: rtl/dref_sched_checks.sv
module dref_sched_checks (
    input logic clk,
    input logic rst_n,
    input logic ref_gnt,
    input logic ref_req,
    input logic init_done,
    input logic pin_own,
    input logic ras_n,
    input logic cas_n,
    input logic we_n
);
    a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    a_r3_cas_held_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n)) |-> !cas_n);

    a_r4_we_high_at_ras_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> we_n);

    a_r6_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r7_own_before_init: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (pin_own && !ref_req));

    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> ref_req);

    a_r9_grant_takes_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> pin_own);

    a_r11_idle_pins_high: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_own |-> (ras_n && cas_n));
endmodule

bind dram_refresh_sched dref_sched_checks u_chk (.*);

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
    localparam int REFI  = 60;
    localparam int PAUSE = 30;
    localparam int INITC = 8;
    localparam int MAXP  = 4;
    localparam int TRP   = 2;
    localparam int TCSR  = 1;
    localparam int TRAS  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, init_done, pin_own, ras_n, cas_n, we_n;

    int checks = 0;
    int failures = 0;
    int fall_cnt = 0;

    always #10 clk = ~clk;

    dram_refresh_sched #(
        .REFI_CYCLES(REFI), .PAUSE_CYCLES(PAUSE), .INIT_CYCLES(INITC),
        .MAX_PENDING(MAXP), .T_RP(TRP), .T_CSR(TCSR), .T_RAS(TRAS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .init_done(init_done), .pin_own(pin_own), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Port monitor: strobe ordering and widths, sampled at falling edges
    logic prev_ras = 1'b1;
    int   ras_hi_run = 0;
    int   cas_lead_run = 0;
    int   ras_lo_run = 0;
    bit   cas_stayed = 1'b1;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ras <= 1'b1; ras_hi_run <= 0; cas_lead_run <= 0;
            ras_lo_run <= 0; cas_stayed <= 1'b1; fall_cnt <= 0;
        end else begin
            if (prev_ras && !ras_n) begin
                fall_cnt <= fall_cnt + 1;
                chk(cas_lead_run >= TCSR, "R3 cas lead before ras fall", cas_lead_run, TCSR);
                chk(we_n == 1'b1, "R4 we_n at ras fall", we_n, 1);
                chk(ras_hi_run >= TRP, "R5 ras precharge", ras_hi_run, TRP);
                ras_lo_run <= 1;
                cas_stayed <= !cas_n;
            end else if (!prev_ras && ras_n) begin
                chk(ras_lo_run == TRAS, "R5 ras low width", ras_lo_run, TRAS);
                chk(cas_stayed, "R3 cas low through ras low", cas_stayed, 1);
                ras_hi_run <= 1;
                cas_lead_run <= 0;
            end else if (!ras_n) begin
                ras_lo_run <= ras_lo_run + 1;
                if (cas_n) cas_stayed <= 1'b0;
            end else begin
                ras_hi_run <= ras_hi_run + 1;
                cas_lead_run <= cas_n ? 0 : cas_lead_run + 1;
            end
            prev_ras <= ras_n;
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ras_n == 1 && cas_n == 1 && we_n == 1, "R1 strobes high in reset",
            {ras_n, cas_n, we_n}, 7);
        chk(init_done == 0 && ref_req == 0, "R1 flags low in reset", {init_done, ref_req}, 0);
        chk(pin_own == 1, "R1 pin_own in reset", pin_own, 1);
    endtask

    task automatic t_pause();
        int n = 0;
        bit req_seen = 0;
        bit own_lost = 0;
        ref_gnt = 1'b1;
        rst_n = 1'b1;
        while (cas_n && n < PAUSE + 50) begin
            @(negedge clk);
            n++;
            if (ref_req) req_seen = 1;
            if (!pin_own) own_lost = 1;
        end
        chk(n == PAUSE + TRP, "R2 first cas fall after pause", n, PAUSE + TRP);
        chk(!req_seen, "R7 no request during pause", req_seen, 0);
        chk(!own_lost, "R7 pins owned during pause", own_lost, 0);
    endtask

    task automatic t_init();
        int n = 0;
        bit req_seen = 0;
        while (!init_done && n < 500) begin
            if (ref_req || !pin_own) req_seen = 1;
            @(negedge clk);
            n++;
        end
        ref_gnt = 1'b0;
        chk(init_done == 1, "R6 init_done rises", init_done, 1);
        chk(fall_cnt == INITC, "R6 init cycle count with grant held (R7)", fall_cnt, INITC);
        chk(!req_seen, "R7 no request or release before init_done", req_seen, 0);
    endtask

    task automatic t_interval();
        int n = 0;
        while (!ref_req && n < REFI + 20) begin
            @(negedge clk);
            n++;
        end
        chk(n == REFI, "R8 first request delay", n, REFI);
    endtask

    task automatic t_saturate();
        bit dropped = 0;
        int f0;
        repeat (5 * REFI + 2) begin
            @(negedge clk);
            if (!ref_req) dropped = 1;
        end
        chk(!dropped, "R8 request held until grant", dropped, 0);
        chk(init_done == 1, "R6 init_done stays high", init_done, 1);
        f0 = fall_cnt;
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        chk(pin_own == 1, "R9 pins taken after grant", pin_own, 1);
        while (pin_own) @(negedge clk);
        chk(fall_cnt - f0 == MAXP, "R10 saturated backlog burst", fall_cnt - f0, MAXP);
        chk(ref_req == 0, "R9 request clear after burst", ref_req, 0);
    endtask

    task automatic t_pair();
        int f0;
        int n = 0;
        while (!ref_req && n < 2 * REFI) begin
            @(negedge clk);
            n++;
        end
        repeat (REFI + 2) @(negedge clk);
        f0 = fall_cnt;
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        while (pin_own) @(negedge clk);
        chk(fall_cnt - f0 == 2, "R9 two pending run back to back", fall_cnt - f0, 2);
        chk(ref_req == 0 && pin_own == 0, "R9 pins returned", {ref_req, pin_own}, 0);
    endtask

    task automatic t_idle_grant();
        int f0 = fall_cnt;
        bit bad = 0;
        chk(ref_req == 0, "R11 precondition no request", ref_req, 0);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        repeat (10) begin
            if (pin_own || !ras_n || !cas_n) bad = 1;
            @(negedge clk);
        end
        chk(!bad, "R11 grant without request ignored", bad, 0);
        chk(fall_cnt == f0, "R11 no cycle started", fall_cnt - f0, 0);
    endtask

    bit finished = 0;

    initial begin
        t_reset();
        t_pause();
        t_init();
        t_interval();
        t_saturate();
        t_pair();
        t_idle_grant();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule